// File: doc/BRIEF.md
# Zero-Overhead Loop Instruction Cache

This block sits beside the instruction decoder of a small DSP sequencer and runs hardware loops. A loop-start command gives the address of the word that follows it, a body length N of 1 to 15 words and an iteration count K. The block fetches the N body words from program memory once, issues each one as it arrives and writes a copy into internal storage. It then replays the stored body for the remaining passes without fetching again. A repeat command runs the most recently stored body again for a new count, taking every word from storage.

The iteration count is held in a 7-bit count register that can be written and read. A K of zero in the command selects the value already in the register. A nonzero K overwrites the register. The register counts down once at the end of each pass and reads zero when the loop ends. When the last word has been taken, the block sends a one-cycle resume pulse with the address at which the sequencer should continue.

Issued words leave on a valid/ready stream. A word is transferred on a cycle where both `iss_valid` and `iss_ready` are high. While `iss_ready` is low, `iss_valid` stays high and `iss_data` and `iss_cached` hold still. The block raises a program-memory fetch only on a cycle where the word it returns is transferred at once. Program memory answers within the same cycle. Commands are accepted on a cycle where `cmd_valid` and `cmd_ready` are both high.

Top module: `loop_cache_ctrl`

## Requirements
- R1: `cmd_ready` is high only while no loop is running and no idle repeat cycle is pending. A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_op` = 0 selects loop-start and `cmd_op` = 1 selects repeat.
- R2: On the first pass of a loop-start, the block fetches the addresses `cmd_pc` to `cmd_pc`+N-1 in order. Each fetched word is issued with `iss_cached` = 0, and each transferred word costs exactly one fetch.
- R3: Every pass after the first issues the same N words from internal storage, with `iss_cached` = 1 and no fetch.
- R4: A nonzero K loads the count register with K. K = 0 uses the count register as it stands. A stored count of zero runs a single pass.
- R5: The count register decrements by one at the end of each pass and reads 0 when the loop completes. It can be read on `cnt_rd` at all times. At the first replayed word it reads the number of passes minus one.
- R6: A count-register write made while a loop is running has no effect. When a write and an accepted command fall in the same cycle, the command's count handling wins. An idle write is visible on `cnt_rd` in the next cycle.
- R7: A repeat command replays the most recently stored body (its address and length) for its own K passes. All of those words are cached and no fetch is made. Its `cmd_len` field is ignored.
- R8: A loop-start issues its first word in the cycle after acceptance. A repeat leaves one empty cycle and issues its first word two cycles after acceptance.
- R9: In the cycle after the final transfer, `resume_valid` pulses for one cycle. `resume_pc` then reads `cmd_pc`+N for a loop-start, or `cmd_pc` for a repeat.
- R10: While `iss_valid` is high and `iss_ready` is low, the word and its flag stay stable. `fetch_req` is high only on a first-pass cycle with `iss_ready` high.
- R11: After reset the block is idle with `cmd_ready` = 1, `iss_valid` = 0, `fetch_req` = 0, `resume_valid` = 0 and `cnt_rd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 1 | 0 = loop-start, 1 = repeat |
| cmd_len | input | 4 | Body length N (1 to 15), used by loop-start |
| cmd_cnt | input | 7 | Iteration count K; 0 selects the count register |
| cmd_pc | input | 16 | Address of the word after the command |
| fetch_req | output | 1 | Program-memory read strobe |
| fetch_addr | output | 16 | Program-memory read address |
| fetch_data | input | 16 | Program-memory word, same cycle |
| iss_valid | output | 1 | Issued word valid |
| iss_ready | input | 1 | Consumer takes the issued word |
| iss_data | output | 16 | Issued instruction word |
| iss_cached | output | 1 | Word came from internal storage |
| resume_valid | output | 1 | Loop finished; one-cycle pulse |
| resume_pc | output | 16 | Address at which the sequencer continues |
| cnt_wr_en | input | 1 | Count-register write strobe |
| cnt_wr_data | input | 7 | Count-register write value |
| cnt_rd | output | 7 | Count-register value |

## Verification
The bench covers the length extremes of one and fifteen words, a count of 127 and a count of one. A design with an off-by-one pass-end compare would issue too many or too few words. A design that replayed a one-pass loop would report cached words where none belong. It also runs count-register loops, including a stored zero, where a design that took zero literally would hang or issue nothing. It also runs repeats with a misleading length field, where a design that read `cmd_len` or refetched would show the wrong word count or nonzero fetches. Back-pressure runs catch a design that fetched on stalled cycles or let the word change. Writes during a loop and in the same cycle as a command catch a register that accepted them and so finished with a nonzero count or the wrong pass total.

// File: rtl/loop_cache_pkg.sv
package loop_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_GAP    = 2'd2,
    ST_REPLAY = 2'd3
  } seq_state_t;

  localparam logic OP_START  = 1'b0;
  localparam logic OP_REPEAT = 1'b1;
endpackage

// File: rtl/lc_body_store.sv
module lc_body_store #(
  parameter int IW    = 16,
  parameter int DEPTH = 15,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [IW-1:0] wr_data,
  input  logic [LW-1:0] rd_idx,
  output logic [IW-1:0] rd_data
);
  logic [IW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == LW'(g))) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == LW'(i)) rd_data = slot_q[i];
    end
  end
endmodule

// File: rtl/lc_iter_count.sv
module lc_iter_count #(
  parameter int KW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          start_load,
  input  logic [KW-1:0] load_k,
  input  logic          pass_end,
  input  logic          wr_en,
  input  logic [KW-1:0] wr_data,
  output logic [KW-1:0] cnt,
  output logic          last_pass
);
  logic [KW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_load) begin
      if (load_k != '0)      cnt_q <= load_k;
      else if (cnt_q == '0)  cnt_q <= KW'(1);
    end else if (pass_end) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (wr_en && !busy) begin
      cnt_q <= wr_data;
    end
  end

  assign cnt       = cnt_q;
  assign last_pass = (cnt_q == KW'(1));

  // R6: a running loop only moves the count at pass ends
  p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pass_end && !start_load) |=> $stable(cnt_q));

  // R4: a started loop never holds a zero count
  p_loaded_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_load |=> (cnt_q != '0));
endmodule

// File: rtl/lc_seq.sv
module lc_seq
  import loop_cache_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [LW-1:0] cmd_len,
  input  logic [AW-1:0] cmd_pc,
  input  logic          iss_ready,
  input  logic          last_pass,
  output logic          cmd_ready,
  output logic          start_load,
  output logic          fill_act,
  output logic          replay_act,
  output logic          pass_end,
  output logic          busy,
  output logic [LW-1:0] slot,
  output logic [AW-1:0] fetch_addr,
  output logic          resume_valid,
  output logic [AW-1:0] resume_pc
);
  seq_state_t    state_q;
  logic [LW-1:0] slot_q, len_q;
  logic [AW-1:0] base_q, ret_q, rpc_q;
  logic          rv_q;
  logic          accept, xfer;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign busy       = !cmd_ready;
  assign accept     = cmd_valid && cmd_ready;
  assign start_load = accept;
  assign fill_act   = (state_q == ST_FILL);
  assign replay_act = (state_q == ST_REPLAY);
  assign xfer       = (fill_act || replay_act) && iss_ready;
  assign pass_end   = xfer && (slot_q == len_q - 1'b1);
  assign slot       = slot_q;
  assign fetch_addr = base_q + AW'(slot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      len_q   <= LW'(1);
      base_q  <= '0;
      ret_q   <= '0;
      rv_q    <= 1'b0;
      rpc_q   <= '0;
    end else begin
      rv_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            slot_q <= '0;
            if (cmd_op == OP_START) begin
              state_q <= ST_FILL;
              base_q  <= cmd_pc;
              len_q   <= cmd_len;
              ret_q   <= cmd_pc + AW'(cmd_len);
            end else begin
              state_q <= ST_GAP;
              ret_q   <= cmd_pc;
            end
          end
        end
        ST_GAP: state_q <= ST_REPLAY;
        default: begin
          if (pass_end) begin
            slot_q <= '0;
            if (last_pass) begin
              state_q <= ST_IDLE;
              rv_q    <= 1'b1;
              rpc_q   <= ret_q;
            end else begin
              state_q <= ST_REPLAY;
            end
          end else if (xfer) begin
            slot_q <= slot_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign resume_valid = rv_q;
  assign resume_pc    = rpc_q;

  // R8: loop-start issues straight away, repeat inserts one empty cycle
  p_start_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_START) |=> fill_act);
  p_repeat_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_REPEAT) |=> (!fill_act && !replay_act));

  // R2: the slot index never leaves the body
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_act || replay_act) |-> (slot_q < len_q));

  // R9: completion is a single-cycle pulse
  p_resume_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> !resume_valid);
endmodule

// File: rtl/loop_cache_ctrl.sv
module loop_cache_ctrl
  import loop_cache_pkg::*;
#(
  parameter int AW     = 16,
  parameter int IW     = 16,
  parameter int MAXLEN = 15,
  parameter int KW     = 7,
  localparam int LW    = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [LW-1:0] cmd_len,
  input  logic [KW-1:0] cmd_cnt,
  input  logic [AW-1:0] cmd_pc,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic [IW-1:0] fetch_data,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [IW-1:0] iss_data,
  output logic          iss_cached,
  output logic          resume_valid,
  output logic [AW-1:0] resume_pc,
  input  logic          cnt_wr_en,
  input  logic [KW-1:0] cnt_wr_data,
  output logic [KW-1:0] cnt_rd
);
  logic          start_load, fill_act, replay_act, pass_end, busy, last_pass;
  logic [LW-1:0] slot;
  logic [IW-1:0] store_rd;

  lc_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_pc(cmd_pc), .iss_ready(iss_ready),
    .last_pass(last_pass), .cmd_ready(cmd_ready), .start_load(start_load),
    .fill_act(fill_act), .replay_act(replay_act), .pass_end(pass_end),
    .busy(busy), .slot(slot), .fetch_addr(fetch_addr),
    .resume_valid(resume_valid), .resume_pc(resume_pc)
  );

  lc_iter_count #(.KW(KW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_load(start_load),
    .load_k(cmd_cnt), .pass_end(pass_end), .wr_en(cnt_wr_en),
    .wr_data(cnt_wr_data), .cnt(cnt_rd), .last_pass(last_pass)
  );

  lc_body_store #(.IW(IW), .DEPTH(MAXLEN), .LW(LW)) u_store (
    .clk(clk), .wr_en(fill_act && iss_ready), .wr_idx(slot),
    .wr_data(fetch_data), .rd_idx(slot), .rd_data(store_rd)
  );

  assign fetch_req  = fill_act && iss_ready;
  assign iss_valid  = fill_act || replay_act;
  assign iss_cached = replay_act;
  assign iss_data   = fill_act ? fetch_data : store_rd;

  // R10: a stalled word stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_data) && $stable(iss_cached)));

  // R5: a finished loop leaves a zero count
  p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> (cnt_rd == '0));

  // R3: a replayed word never comes with a fetch
  p_cached_nofetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cached) |-> !fetch_req);
endmodule

// File: tb/sim_loop_cache_ctrl.sv
module sim_loop_cache_ctrl;
  typedef struct packed {
    logic        op;
    logic [15:0] pc;
    logic [3:0]  len;
    logic [6:0]  k;
    logic        wr;
    logic [6:0]  wv;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0100, 4'd4,  7'd3,   1'b0, 7'd0, 1'b0},
    '{1'b0, 16'h0200, 4'd1,  7'd5,   1'b0, 7'd0, 1'b0},
    '{1'b0, 16'h0300, 4'd15, 7'd2,   1'b0, 7'd0, 1'b1},
    '{1'b0, 16'h0400, 4'd3,  7'd0,   1'b1, 7'd6, 1'b0},
    '{1'b1, 16'h0500, 4'd9,  7'd2,   1'b0, 7'd0, 1'b0},
    '{1'b0, 16'h0600, 4'd5,  7'd0,   1'b1, 7'd0, 1'b0},
    '{1'b1, 16'h0700, 4'd2,  7'd0,   1'b1, 7'd4, 1'b1},
    '{1'b0, 16'h0800, 4'd2,  7'd127, 1'b0, 7'd0, 1'b0},
    '{1'b0, 16'h0900, 4'd7,  7'd1,   1'b0, 7'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
  logic [3:0] cmd_len = '0;
  logic [6:0] cmd_cnt = '0;
  logic [15:0] cmd_pc = '0;
  logic fetch_req;
  logic [15:0] fetch_addr, fetch_data;
  logic iss_valid, iss_ready = 1'b1, iss_cached;
  logic [15:0] iss_data;
  logic resume_valid;
  logic [15:0] resume_pc;
  logic cnt_wr_en = 1'b0;
  logic [6:0] cnt_wr_data = '0, cnt_rd;

  always #4 clk = ~clk;

  function automatic logic [15:0] pword(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8]};
  endfunction

  assign fetch_data = pword(fetch_addr);

  loop_cache_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_cnt(cmd_cnt), .cmd_pc(cmd_pc),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_data(iss_data),
    .iss_cached(iss_cached), .resume_valid(resume_valid), .resume_pc(resume_pc),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd(cnt_rd)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0, n_got = 0, n_fetch = 0, acc_cyc = 0, first_cyc = 0;
  logic [15:0] got_d [2048];
  logic        got_c [2048];
  logic        seen_cached = 1'b0, done_seen = 1'b0, stall_on = 1'b0;
  logic [6:0]  cnt_at_cached = '0;
  logic [15:0] got_rpc = '0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (iss_valid && iss_ready) begin
        if (n_got < 2048) begin
          got_d[n_got] = iss_data;
          got_c[n_got] = iss_cached;
        end
        if (n_got == 0) first_cyc = cyc;
        if (iss_cached && !seen_cached) begin
          seen_cached = 1'b1;
          cnt_at_cached = cnt_rd;
        end
        n_got++;
      end
      if (fetch_req) n_fetch++;
      if (cmd_valid && cmd_ready) acc_cyc = cyc;
      if (resume_valid) begin
        done_seen = 1'b1;
        got_rpc = resume_pc;
      end
    end
    iss_ready = !(stall_on && (cyc % 3 == 1));
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic clear_mon();
    n_got = 0; n_fetch = 0; seen_cached = 1'b0; done_seen = 1'b0;
  endtask

  task automatic write_cnt(input logic [6:0] v);
    @(posedge clk); #2;
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    @(posedge clk); #2;
    cnt_wr_en = 1'b0;
  endtask

  task automatic send_cmd(input logic op, input logic [15:0] pc, input logic [3:0] len,
                          input logic [6:0] k);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_len = len; cmd_cnt = k;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_seen) @(posedge clk);
  endtask

  logic [15:0] last_pc = '0;
  int          last_len = 1;

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R11: reset state
    check("R11", "cmd_ready", int'(cmd_ready), 1);
    check("R11", "iss_valid", int'(iss_valid), 0);
    check("R11", "cnt_rd", int'(cnt_rd), 0);
    check("R11", "fetch_req", int'(fetch_req), 0);
    check("R11", "resume_valid", int'(resume_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t   t = VECS[v];
      automatic int     passes, n, total, bad;
      automatic logic [15:0] base;
      if (t.wr) write_cnt(t.wv);
      passes = (t.k != 0) ? int'(t.k) : ((t.wr && t.wv != 0) ? int'(t.wv) : 1);
      base   = t.op ? last_pc : t.pc;
      n      = t.op ? last_len : int'(t.len);
      total  = passes * n;
      stall_on = t.stall;
      clear_mon();
      send_cmd(t.op, t.pc, t.len, t.k);
      wait_done();
      #3;
      stall_on = 1'b0;
      bad = 0;
      for (int i = 0; i < total && i < 2048; i++) begin
        automatic logic expc = t.op ? 1'b1 : (i >= n);
        if (got_d[i] != pword(base + 16'(i % n)) || got_c[i] != expc) bad++;
      end
      // R2 R3 R7: issued stream and from-storage flags
      check(t.op ? "R7" : "R2", $sformatf("v%0d stream mismatches", v), bad, 0);
      check("R3", $sformatf("v%0d word count", v), n_got, total);
      check(t.op ? "R7" : "R2", $sformatf("v%0d fetches", v), n_fetch, t.op ? 0 : n);
      check("R9", $sformatf("v%0d resume_pc", v), int'(got_rpc),
            int'(t.op ? t.pc : t.pc + 16'(t.len)));
      check("R9", $sformatf("v%0d pulse ends", v), int'(resume_valid), 0);
      check("R5", $sformatf("v%0d final count", v), int'(cnt_rd), 0);
      if (t.k == 0) check("R4", $sformatf("v%0d count-reg passes", v), n_got / n, passes);
      if (passes > 1 && !t.op)
        check("R5", $sformatf("v%0d count at first replay", v), int'(cnt_at_cached), passes - 1);
      if (!t.stall)
        check("R8", $sformatf("v%0d overhead cycles", v), first_cyc - acc_cyc, t.op ? 2 : 1);
      if (!t.op) begin
        last_pc = t.pc;
        last_len = int'(t.len);
      end
    end

    // R6: write while busy is ignored
    clear_mon();
    send_cmd(1'b0, 16'h0A00, 4'd3, 7'd4);
    repeat (2) @(posedge clk);
    #2; cnt_wr_en = 1'b1; cnt_wr_data = 7'd9;
    @(posedge clk); #2; cnt_wr_en = 1'b0;
    wait_done();
    #3;
    check("R6", "busy write pass total", n_got, 12);
    check("R6", "busy write final count", int'(cnt_rd), 0);

    // R6: idle write becomes visible
    write_cnt(7'd5);
    #1;
    check("R6", "idle write readback", int'(cnt_rd), 5);

    // R6: command and write in the same cycle, command wins
    clear_mon();
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_pc = 16'h0B00; cmd_len = 4'd2; cmd_cnt = 7'd3;
    cnt_wr_en = 1'b1; cnt_wr_data = 7'd40;
    @(posedge clk); #2;
    cmd_valid = 1'b0; cnt_wr_en = 1'b0;
    wait_done();
    #3;
    check("R6", "same-cycle pass total", n_got, 6);
    check("R6", "same-cycle final count", int'(cnt_rd), 0);

    // R1: cmd_ready low while running
    clear_mon();
    send_cmd(1'b0, 16'h0C00, 4'd2, 7'd2);
    #1;
    check("R1", "cmd_ready during loop", int'(cmd_ready), 0);
    wait_done();
    #3;
    check("R1", "cmd_ready after loop", int'(cmd_ready), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule